// File: doc/BRIEF.md
# Audio Sample Slot Formatter

This block sits between a stereo PCM sample stream and the line encoder of a serial digital audio transmitter. Each time the encoder asks for a frame, the block takes one left/right sample pair from a valid/ready input, if one is offered. It places each sample in a 24-bit subframe payload and applies channel routing and per-channel muting. One cycle later it presents the left and right payloads to the encoder.

Samples arrive either as full 24-bit words or as 16-bit words in the low half of the input bus. A 16-bit sample can sit at the bottom, the middle or the top of the 24-bit slot. The encoder may ask for a frame when the input has nothing to give, or while a hold control freezes the input. In that case the block fills the frame with zeros, with the selected mute word, or with a repeat of the last real frame, as software chooses. A sticky flag records that an underrun happened. Biphase coding, preambles, parity and channel-status bits belong to the encoder and are not handled here.

Top module: `audio_slot_formatter`

## Requirements
- R1: `inReady` equals `frameReq && !hold`. A sample pair is consumed exactly in a cycle where `inValid` and `inReady` are both high.
- R2: `outValid` is high for exactly the one cycle after each cycle with `frameReq` high. In cycles without a request, `outLeft` and `outRight` keep their values.
- R3: With `mode16` = 0, a consumed pair is passed through unchanged as the 24-bit payloads.
- R4: With `mode16` = 1, only bits 15:0 of each input are used. `alignSel` 0 gives {8 zeros, sample}, 1 gives {4 zeros, sample, 4 zeros}, 2 gives {sample, 8 zeros}, and 3 behaves as 0.
- R5: `swapSel` 0 passes the channels straight through, 1 exchanges left and right, 2 sends left on both channels, and 3 sends right on both channels.
- R6: `muteSel` picks the mute word: 0→0x000000, 1→0x800000, 2→0x080000, 3→0x008000, 4→0x000001, 5→0x000010, 6→0x000100, 7→0x000000.
- R7: `muteLeft` and `muteRight` act independently. They are applied after the underrun fill and after the swap, so a muted channel always carries the mute word.
- R8: A fill frame (requested with no pair consumed) under `underrunMode` 0 or 3 carries zeros on both channels.
- R9: A fill frame under `underrunMode` 1 carries the selected mute word on both channels.
- R10: A fill frame under `underrunMode` 2 repeats the last consumed pair, after alignment. This stored pair resets to zero, so a repeat before any data sends zeros.
- R11: While `hold` is high, a request consumes nothing even if `inValid` is high, produces a fill frame, and does not raise the underrun flag.
- R12: `underrunFlag` goes high in the cycle after a request made with `inValid` low and `hold` low. It stays high until an `underrunClr` pulse. A new underrun in the same cycle as the clear wins over the clear.
- R13: After reset, `outValid`, `outLeft`, `outRight` and `underrunFlag` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample pair available |
| inReady | output | 1 | Pair consumed this cycle if inValid |
| inLeft | input | 24 | Left sample |
| inRight | input | 24 | Right sample |
| mode16 | input | 1 | 1: 16-bit samples in bits 15:0 |
| alignSel | input | 2 | Slot position of 16-bit samples |
| swapSel | input | 2 | Channel routing code |
| muteLeft | input | 1 | Send mute word on left |
| muteRight | input | 1 | Send mute word on right |
| muteSel | input | 3 | Mute word select |
| underrunMode | input | 2 | Fill choice for frames without data |
| hold | input | 1 | Freeze input consumption |
| frameReq | input | 1 | Encoder frame request strobe |
| underrunClr | input | 1 | Clear pulse for the underrun flag |
| outValid | output | 1 | Payload pair valid |
| outLeft | output | 24 | Left subframe payload |
| outRight | output | 24 | Right subframe payload |
| underrunFlag | output | 1 | Sticky underrun indicator |

## Verification
The assertions watch the behaviour that holds on every cycle. These are the gating of `inReady` by request and hold, the one-cycle response of `outValid`, payload stability between requests, the mute word on any muted channel, and the setting of the sticky flag when a request finds no data. The placement of 16-bit samples in the slot, the four routing codes, the fill choices, and the repeat of stored data depend on configuration and on the history of the stream. Only the directed scenarios show those, by comparing payloads against values worked out in the bench. The same holds for zeros before any data and for set-over-clear on the flag.

// File: rtl/slot_fmt_pkg.sv
package slot_fmt_pkg;
  localparam int SLOT_W = 24;
  localparam int HALF_W = 16;
  localparam int PAD_W  = SLOT_W - HALF_W;
  localparam int MID_W  = PAD_W / 2;

  typedef struct packed {
    logic take;
    logic emit;
  } strobe_t;

  function automatic logic [SLOT_W-1:0] muteWordOf(input logic [2:0] sel);
    logic [SLOT_W-1:0] w;
    case (sel)
      3'd1: w = 24'h800000;
      3'd2: w = 24'h080000;
      3'd3: w = 24'h008000;
      3'd4: w = 24'h000001;
      3'd5: w = 24'h000010;
      3'd6: w = 24'h000100;
      default: w = '0;
    endcase
    return w;
  endfunction

  function automatic logic [SLOT_W-1:0] placeSample(input logic [SLOT_W-1:0] raw,
                                                    input logic is16,
                                                    input logic [1:0] pos);
    logic [SLOT_W-1:0] w;
    if (!is16) w = raw;
    else begin
      case (pos)
        2'd1: w = {{MID_W{1'b0}}, raw[HALF_W-1:0], {MID_W{1'b0}}};
        2'd2: w = {raw[HALF_W-1:0], {PAD_W{1'b0}}};
        default: w = {{PAD_W{1'b0}}, raw[HALF_W-1:0]};
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/slot_fmt_ctrl.sv
module slot_fmt_ctrl
  import slot_fmt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameReq,
  input  logic    hold,
  input  logic    inValid,
  input  logic    underrunClr,
  output logic    inReady,
  output strobe_t strb,
  output logic    underrunFlag
);
  logic starve;

  always_comb begin
    inReady   = frameReq && !hold;
    strb.take = inReady && inValid;
    strb.emit = frameReq;
    starve    = inReady && !inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) underrunFlag <= 1'b0;
    else if (starve) underrunFlag <= 1'b1;
    else if (underrunClr) underrunFlag <= 1'b0;
  end
endmodule

// File: rtl/slot_fmt_datapath.sv
module slot_fmt_datapath
  import slot_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [SLOT_W-1:0] inLeft,
  input  logic [SLOT_W-1:0] inRight,
  input  logic              mode16,
  input  logic [1:0]        alignSel,
  input  logic [1:0]        swapSel,
  input  logic              muteLeft,
  input  logic              muteRight,
  input  logic [2:0]        muteSel,
  input  logic [1:0]        underrunMode,
  output logic              outValid,
  output logic [SLOT_W-1:0] outLeft,
  output logic [SLOT_W-1:0] outRight
);
  logic [SLOT_W-1:0] fmtLeft, fmtRight, lastLeft, lastRight;
  logic [SLOT_W-1:0] srcLeft, srcRight, swLeft, swRight, finLeft, finRight;
  logic [SLOT_W-1:0] muteWord;

  always_comb begin
    fmtLeft  = placeSample(inLeft, mode16, alignSel);
    fmtRight = placeSample(inRight, mode16, alignSel);
    muteWord = muteWordOf(muteSel);
    if (strb.take) begin
      srcLeft  = fmtLeft;
      srcRight = fmtRight;
    end else begin
      case (underrunMode)
        2'd1: begin srcLeft = muteWord; srcRight = muteWord; end
        2'd2: begin srcLeft = lastLeft; srcRight = lastRight; end
        default: begin srcLeft = '0; srcRight = '0; end
      endcase
    end
    case (swapSel)
      2'd1: begin swLeft = srcRight; swRight = srcLeft;  end
      2'd2: begin swLeft = srcLeft;  swRight = srcLeft;  end
      2'd3: begin swLeft = srcRight; swRight = srcRight; end
      default: begin swLeft = srcLeft; swRight = srcRight; end
    endcase
    finLeft  = muteLeft  ? muteWord : swLeft;
    finRight = muteRight ? muteWord : swRight;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outLeft   <= '0;
      outRight  <= '0;
      lastLeft  <= '0;
      lastRight <= '0;
    end else begin
      outValid <= strb.emit;
      if (strb.emit) begin
        outLeft  <= finLeft;
        outRight <= finRight;
      end
      if (strb.take) begin
        lastLeft  <= fmtLeft;
        lastRight <= fmtRight;
      end
    end
  end
endmodule

// File: rtl/audio_slot_formatter.sv
module audio_slot_formatter
  import slot_fmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [SLOT_W-1:0] inLeft,
  input  logic [SLOT_W-1:0] inRight,
  input  logic              mode16,
  input  logic [1:0]        alignSel,
  input  logic [1:0]        swapSel,
  input  logic              muteLeft,
  input  logic              muteRight,
  input  logic [2:0]        muteSel,
  input  logic [1:0]        underrunMode,
  input  logic              hold,
  input  logic              frameReq,
  input  logic              underrunClr,
  output logic              outValid,
  output logic [SLOT_W-1:0] outLeft,
  output logic [SLOT_W-1:0] outRight,
  output logic              underrunFlag
);
  strobe_t strb;

  slot_fmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameReq(frameReq), .hold(hold),
    .inValid(inValid), .underrunClr(underrunClr), .inReady(inReady),
    .strb(strb), .underrunFlag(underrunFlag)
  );

  slot_fmt_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inLeft(inLeft), .inRight(inRight),
    .mode16(mode16), .alignSel(alignSel), .swapSel(swapSel),
    .muteLeft(muteLeft), .muteRight(muteRight), .muteSel(muteSel),
    .underrunMode(underrunMode), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight)
  );
endmodule

// File: rtl/slot_fmt_checks.sv
module slot_fmt_checks
  import slot_fmt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              frameReq,
  input logic              hold,
  input logic              inValid,
  input logic              inReady,
  input logic              muteLeft,
  input logic              muteRight,
  input logic [2:0]        muteSel,
  input logic              outValid,
  input logic [SLOT_W-1:0] outLeft,
  input logic [SLOT_W-1:0] outRight,
  input logic              underrunFlag,
  input logic              underrunClr
);
  assert_ready_gated_R1: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (frameReq && !hold));

  assert_hold_blocks_R11: assert property (@(posedge clk) disable iff (!rstN)
    hold |-> !inReady);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    frameReq |=> outValid);

  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !frameReq |=> (!outValid && $stable(outLeft) && $stable(outRight)));

  assert_mute_left_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameReq && muteLeft) |=> (outLeft == muteWordOf($past(muteSel))));

  assert_mute_right_R7: assert property (@(posedge clk) disable iff (!rstN)
    (frameReq && muteRight) |=> (outRight == muteWordOf($past(muteSel))));

  assert_flag_set_R12: assert property (@(posedge clk) disable iff (!rstN)
    (frameReq && !hold && !inValid) |=> underrunFlag);

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (underrunClr && !(frameReq && !hold && !inValid)) |=> !underrunFlag);
endmodule

bind audio_slot_formatter slot_fmt_checks u_chk (
  .clk(clk), .rstN(rstN), .frameReq(frameReq), .hold(hold), .inValid(inValid),
  .inReady(inReady), .muteLeft(muteLeft), .muteRight(muteRight),
  .muteSel(muteSel), .outValid(outValid), .outLeft(outLeft),
  .outRight(outRight), .underrunFlag(underrunFlag), .underrunClr(underrunClr)
);

// File: tb/sim_audio_slot_formatter.sv
`timescale 1ns/1ps
module sim_audio_slot_formatter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inReady;
  logic [23:0] inLeft = '0, inRight = '0;
  logic mode16 = 1'b0;
  logic [1:0] alignSel = '0, swapSel = '0, underrunMode = '0;
  logic muteLeft = 1'b0, muteRight = 1'b0;
  logic [2:0] muteSel = '0;
  logic hold = 1'b0, frameReq = 1'b0, underrunClr = 1'b0;
  logic outValid, underrunFlag;
  logic [23:0] outLeft, outRight;
  int errors = 0, checks = 0;
  logic readyObs;
  bit done = 0;

  always #10 clk = ~clk;

  audio_slot_formatter u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inLeft(inLeft), .inRight(inRight), .mode16(mode16), .alignSel(alignSel),
    .swapSel(swapSel), .muteLeft(muteLeft), .muteRight(muteRight),
    .muteSel(muteSel), .underrunMode(underrunMode), .hold(hold),
    .frameReq(frameReq), .underrunClr(underrunClr), .outValid(outValid),
    .outLeft(outLeft), .outRight(outRight), .underrunFlag(underrunFlag)
  );

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  // One request; outputs are observable when the task returns.
  task automatic sendFrame(input logic v, input logic [23:0] l, input logic [23:0] r);
    @(negedge clk);
    inValid = v; inLeft = l; inRight = r; frameReq = 1'b1;
    #1 readyObs = inReady;
    @(negedge clk);
    frameReq = 1'b0; inValid = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    chk("R13 outValid", {23'b0, outValid}, 24'h0);
    chk("R13 outLeft", outLeft, 24'h0);
    chk("R13 outRight", outRight, 24'h0);
    chk("R13 flag", {23'b0, underrunFlag}, 24'h0);
  endtask

  task automatic testRepeatBeforeData();
    underrunMode = 2'd2;
    sendFrame(1'b0, 24'h0, 24'h0);
    chk("R10 repeat before data L", outLeft, 24'h0);
    chk("R10 repeat before data R", outRight, 24'h0);
    chk("R2 outValid after request", {23'b0, outValid}, 24'h1);
    underrunMode = 2'd0;
  endtask

  task automatic testPass24();
    mode16 = 1'b0;
    sendFrame(1'b1, 24'h123456, 24'hABCDEF);
    chk("R1 inReady on request", {23'b0, readyObs}, 24'h1);
    chk("R3 pass left", outLeft, 24'h123456);
    chk("R3 pass right", outRight, 24'hABCDEF);
    @(negedge clk);
    chk("R2 outValid drops", {23'b0, outValid}, 24'h0);
    chk("R2 left held", outLeft, 24'h123456);
    chk("R1 inReady idle", {23'b0, inReady}, 24'h0);
  endtask

  task automatic testAlign();
    logic [23:0] exp [4];
    exp[0] = 24'h001234; exp[1] = 24'h012340; exp[2] = 24'h123400; exp[3] = 24'h001234;
    mode16 = 1'b1;
    for (int a = 0; a < 4; a++) begin
      alignSel = a[1:0];
      sendFrame(1'b1, 24'hFF1234, 24'hEE1234);
      chk($sformatf("R4 align %0d left", a), outLeft, exp[a]);
      chk($sformatf("R4 align %0d right", a), outRight, exp[a]);
    end
    mode16 = 1'b0; alignSel = 2'd0;
  endtask

  task automatic testSwap();
    logic [23:0] l = 24'h111111, r = 24'h222222;
    logic [23:0] el [4], er [4];
    el[0] = l; er[0] = r; el[1] = r; er[1] = l; el[2] = l; er[2] = l; el[3] = r; er[3] = r;
    for (int s = 0; s < 4; s++) begin
      swapSel = s[1:0];
      sendFrame(1'b1, l, r);
      chk($sformatf("R5 swap %0d left", s), outLeft, el[s]);
      chk($sformatf("R5 swap %0d right", s), outRight, er[s]);
    end
    swapSel = 2'd0;
  endtask

  task automatic testMuteWords();
    logic [23:0] words [8];
    words[0] = 24'h000000; words[1] = 24'h800000; words[2] = 24'h080000; words[3] = 24'h008000;
    words[4] = 24'h000001; words[5] = 24'h000010; words[6] = 24'h000100; words[7] = 24'h000000;
    muteLeft = 1'b1;
    for (int m = 0; m < 8; m++) begin
      muteSel = m[2:0];
      sendFrame(1'b1, 24'h5A5A5A, 24'h3C3C3C);
      chk($sformatf("R6 mute word %0d", m), outLeft, words[m]);
      chk("R7 right unmuted", outRight, 24'h3C3C3C);
    end
    muteLeft = 1'b0; muteRight = 1'b1; muteSel = 3'd3;
    sendFrame(1'b1, 24'h5A5A5A, 24'h3C3C3C);
    chk("R7 left unmuted", outLeft, 24'h5A5A5A);
    chk("R7 right muted", outRight, 24'h008000);
    muteRight = 1'b0;
  endtask

  task automatic testUnderrunFills();
    mode16 = 1'b1; alignSel = 2'd2;
    sendFrame(1'b1, 24'h00ABCD, 24'h004321);
    mode16 = 1'b0;
    underrunMode = 2'd0;
    sendFrame(1'b0, 24'h777777, 24'h777777);
    chk("R8 zero fill L", outLeft, 24'h0);
    chk("R8 zero fill R", outRight, 24'h0);
    underrunMode = 2'd3;
    sendFrame(1'b0, 24'h777777, 24'h777777);
    chk("R8 mode3 zero L", outLeft, 24'h0);
    underrunMode = 2'd1; muteSel = 3'd1;
    sendFrame(1'b0, 24'h0, 24'h0);
    chk("R9 mute fill L", outLeft, 24'h800000);
    chk("R9 mute fill R", outRight, 24'h800000);
    underrunMode = 2'd2;
    sendFrame(1'b0, 24'h0, 24'h0);
    chk("R10 repeat L", outLeft, 24'hABCD00);
    chk("R10 repeat R", outRight, 24'h432100);
    muteRight = 1'b1; muteSel = 3'd5;
    sendFrame(1'b0, 24'h0, 24'h0);
    chk("R7 mute over repeat R", outRight, 24'h000010);
    chk("R10 repeat L again", outLeft, 24'hABCD00);
    muteRight = 1'b0; alignSel = 2'd0; underrunMode = 2'd0;
  endtask

  task automatic testFlag();
    @(negedge clk); underrunClr = 1'b1;
    @(negedge clk); underrunClr = 1'b0;
    chk("R12 cleared", {23'b0, underrunFlag}, 24'h0);
    sendFrame(1'b0, 24'h0, 24'h0);
    chk("R12 set on underrun", {23'b0, underrunFlag}, 24'h1);
    @(negedge clk); @(negedge clk);
    chk("R12 sticky", {23'b0, underrunFlag}, 24'h1);
    @(negedge clk); underrunClr = 1'b1;
    @(negedge clk); underrunClr = 1'b0;
    chk("R12 clear pulse", {23'b0, underrunFlag}, 24'h0);
    @(negedge clk); underrunClr = 1'b1; frameReq = 1'b1; inValid = 1'b0;
    @(negedge clk); underrunClr = 1'b0; frameReq = 1'b0;
    chk("R12 set wins over clear", {23'b0, underrunFlag}, 24'h1);
    @(negedge clk); underrunClr = 1'b1;
    @(negedge clk); underrunClr = 1'b0;
  endtask

  task automatic testHold();
    underrunMode = 2'd0; hold = 1'b1;
    sendFrame(1'b1, 24'h246802, 24'h135791);
    chk("R11 inReady low", {23'b0, readyObs}, 24'h0);
    chk("R11 fill on hold", outLeft, 24'h0);
    chk("R11 no flag on hold", {23'b0, underrunFlag}, 24'h0);
    underrunMode = 2'd2;
    sendFrame(1'b1, 24'h246802, 24'h135791);
    chk("R11 hold consumed nothing", outLeft, 24'hABCD00);
    hold = 1'b0;
    sendFrame(1'b1, 24'h246802, 24'h135791);
    chk("R1 consumed after hold", outLeft, 24'h246802);
    underrunMode = 2'd0;
  endtask

  initial begin
    testReset();
    testRepeatBeforeData();
    testPass24();
    testAlign();
    testSwap();
    testMuteWords();
    testUnderrunFills();
    testFlag();
    testHold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule